// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received Ethernet frames from a byte stream and lays them into a circular buffer in local memory. The stream has start, end and error flags. Each stored frame gets a 32-bit header in front of it. The header carries a status word and the frame length. The next frame always starts on a 4-byte boundary. The payload bytes are written while the frame arrives. The header goes into its slot one cycle after the last byte, so a host that polls the buffer never sees a header for a frame that is only partly written.

Software running on a host consumes frames and reports its progress through a read-pointer register. That register is written with the consumed offset minus 16. The block compares the read pointer with its own write pointer to drive an empty flag and to decide whether a new frame fits. A frame that does not fit is discarded as a whole. The block also keeps write-1-to-clear event bits and a 24-bit missed-frame counter. The buffer size is chosen at run time from three power-of-two sizes. A mode bit selects how the payload behaves at the end of the buffer: it either folds back to offset 0, or runs on linearly past the nominal end into spare memory.

Top module: `rxr_ring_writer`

## Requirements
- R1: The buffer length is BASE_LEN shifted left by `cfg_size`, and a `cfg_size` value above MAX_SIZE_IDX acts as MAX_SIZE_IDX. With `cfg_nowrap`=0, payload byte addresses are taken modulo the buffer length, so a frame that crosses the end continues at offset 0.
- R2: Each stored frame gets one 32-bit header write (all four byte enables) at its start offset. Bits 31:16 hold the count of stream bytes in the frame, FCS included. Bits 15:0 hold the status: bit1 alignment error (rx_class[0]), bit2 CRC error (rx_class[1]), bit3 too long (rx_class[2]), bit4 runt (rx_class[3]), bit5 bad symbol (rx_err seen on any beat), bit13 broadcast (rx_class[4]), bit14 address match (rx_class[5]) and bit15 multicast (rx_class[6]). Bit0 (good) is set exactly when bits 5:1 are all clear. rx_class is sampled on the end beat.
- R3: Payload byte n of a frame goes to start+4+n in the cycle of its beat. The header is written in the cycle after the end beat, after every payload byte.
- R4: The next frame starts at (start + length + 7) with the low two bits cleared, taken modulo the buffer length.
- R5: A write to `rdptr_wdata` sets the read offset to (value + 16) modulo the buffer length. After reset the read offset is 0.
- R6: `buf_empty` is 1 exactly when the read offset equals the write pointer.
- R7: The free space is the buffer length when the buffer is empty, and (read − write) modulo the length otherwise. A frame is stored only when its length + 8 ≤ free space. If it is not stored, it gets no header, the write pointer does not move, the missed counter goes up by one and int_stat bit4 is set.
- R8: `int_stat` bit0 is set when a good frame is stored, and bit1 when a frame with error status is stored. Each bit is cleared by writing 1 to it through `int_ack`. If a bit is set and acknowledged in the same cycle, the set wins.
- R9: A start beat that arrives during the header cycle of the previous frame discards that whole new frame. It sets int_stat bit6, adds one to the missed counter and moves no pointer.
- R10: `miss_cnt` is 24 bits wide and is cleared by a `miss_clr` pulse.
- R11: With `cfg_nowrap`=1, payload addresses are not folded, so they run linearly past the nominal end. The header offset and the next start still follow R4.
- R12: After reset, `buf_empty`=1, `int_stat`=0, `miss_cnt`=0 and no memory write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_size | input | 2 | Buffer size index |
| cfg_nowrap | input | 1 | 1: payload runs linearly past the end of the buffer |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Symbol error on this beat |
| rx_class | input | 7 | Frame error and address class flags, valid on the end beat |
| rdptr_we | input | 1 | Host read-pointer write strobe |
| rdptr_wdata | input | 16 | Consumed offset minus 16 |
| int_ack_we | input | 1 | Event acknowledge strobe |
| int_ack | input | 16 | Event bits to clear |
| miss_clr | input | 1 | Clears the missed-frame counter |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte enables of the addressed word |
| mem_addr | output | $clog2(BASE_LEN<<MAX_SIZE_IDX)+1 | Byte address |
| mem_wdata | output | 32 | Write data |
| buf_empty | output | 1 | No unconsumed frame |
| int_stat | output | 16 | Event bits 0, 1, 4, 6 |
| miss_cnt | output | 24 | Missed-frame counter |

## Verification
The bench builds the block with BASE_LEN=64 and MAX_SIZE_IDX=2, so the three buffer sizes are 64, 128 and 256 bytes. With sizes that small, a few short frames reach wrap-around, exact-fit and one-byte-too-many cases, as well as the clamping of an illegal size index. A bench memory of 512 bytes is enough to hold linear overrun in no-wrap mode and to show that, in wrap mode, nothing lands past the nominal end.

// File: rtl/rxr_pkg.sv
// Shared constants, types and the header status builder of the receive ring writer.
package rxr_pkg;
    localparam int HDR_BYTES    = 4;   // header size in front of each frame
    localparam int RD_BIAS      = 16;  // host pointer is written as offset minus this
    localparam int SPACE_MARGIN = 8;   // header plus alignment slack kept free
    localparam int INT_OK       = 0;
    localparam int INT_ERR      = 1;
    localparam int INT_OVF      = 4;
    localparam int INT_FIFO     = 6;

    // Class flags sampled on the end beat (bit 0 is align, bit 6 is multicast).
    typedef struct packed {
        logic mcast;
        logic phys;
        logic bcast;
        logic runt;
        logic toolong;
        logic crc;
        logic align;
    } rx_class_t;

    // Form the 16-bit header status word from class flags and the symbol error.
    function automatic logic [15:0] build_status(input rx_class_t c, input logic sym);
        logic [15:0] s;
        s      = '0;
        s[1]   = c.align;
        s[2]   = c.crc;
        s[3]   = c.toolong;
        s[4]   = c.runt;
        s[5]   = sym;
        s[0]   = ~(|s[5:1]);
        s[13]  = c.bcast;
        s[14]  = c.phys;
        s[15]  = c.mcast;
        return s;
    endfunction
endpackage

// File: rtl/rxr_space.sv
// Pointer unit: holds the write pointer and the host read pointer, and derives
// the buffer mask, the free space and the empty flag.
// Assumes BASE_LEN is a power of two, the buffer is at most 64 KiB, and cfg_size
// changes only while the block is in reset.
module rxr_space
    import rxr_pkg::*;
#(
    parameter int BASE_LEN = 8192,
    parameter int MAX_IDX  = 2,
    parameter int AW       = 16,
    parameter int LW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_size,
    input  logic          rdptr_we,
    input  logic [15:0]   rdptr_wdata,
    input  logic          commit,
    input  logic [LW-1:0] commit_len,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] mask,
    output logic [AW-1:0] free,
    output logic          buf_empty
);
    localparam logic [15:0] RD_RESET = 16'(0) - 16'(RD_BIAS);

    logic [1:0]    eff_idx;
    logic [AW-1:0] buf_len;
    logic [15:0]   rd_reg;
    logic [15:0]   rd_sum;
    logic [AW-1:0] rd_off;
    logic [LW:0]   nxt_sum;
    logic [AW-1:0] nxt_ptr;

    // Clamp the size index and derive the buffer length and mask.
    always_comb begin
        eff_idx = (cfg_size > 2'(MAX_IDX)) ? 2'(MAX_IDX) : cfg_size;
        buf_len = AW'(BASE_LEN) << eff_idx;
        mask    = buf_len - AW'(1);
    end

    // Turn the biased host pointer into a read offset and work out the occupancy.
    always_comb begin
        rd_sum    = rd_reg + 16'(RD_BIAS);
        rd_off    = AW'(rd_sum) & mask;
        buf_empty = (rd_off == wr_ptr);
        free      = buf_empty ? buf_len : ((rd_off - wr_ptr) & mask);
    end

    // Next frame start: past header and payload, rounded up to a dword, folded.
    always_comb begin
        nxt_sum = (LW+1)'(wr_ptr) + (LW+1)'(commit_len) + (LW+1)'(HDR_BYTES + 3);
        nxt_ptr = AW'(nxt_sum) & mask & ~AW'(3);
    end

    // Hold the host read-pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_reg <= RD_RESET;
        else if (rdptr_we) rd_reg <= rdptr_wdata;
    end

    // Move the write pointer when a frame header is committed.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_ptr <= '0;
        else if (commit) wr_ptr <= nxt_ptr;
    end

    assert_wr_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr[1:0] == 2'b00);
    assert_wr_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr & ~mask) == '0);
    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(wr_ptr));
endmodule

// File: rtl/rxr_frame.sv
// Frame unit: counts the bytes of the frame in progress, writes payload bytes
// behind the reserved header slot, checks space on every byte, and writes the
// header one cycle after the end beat.
// Assumes one idle cycle between frames; a start beat during the header cycle
// is reported as a discard.
module rxr_frame
    import rxr_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_nowrap,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic          rx_err,
    input  logic [6:0]    rx_class,
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] free,
    output logic          mem_we,
    output logic [3:0]    mem_be,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic          commit,
    output logic [LW-1:0] commit_len,
    output logic          commit_good,
    output logic          drop_evt,
    output logic          fifo_evt
);
    logic          in_frame;
    logic          drop_q;
    logic          sym_q;
    logic [LW-1:0] cnt_q;
    logic          hdr_pend;
    logic [15:0]   hdr_stat;

    logic          live;
    logic [LW-1:0] cnt_in;
    logic [LW-1:0] cnt_new;
    logic          drop_in;
    logic          sym_in;
    logic          fits;
    logic          drop_new;
    logic          wr_byte;
    logic          commit_next;
    logic [AW-1:0] lin_addr;
    logic [AW-1:0] byte_addr;

    // Classify the current beat and decide whether its byte can be stored.
    always_comb begin
        live        = rx_valid && !hdr_pend && (rx_sof || in_frame);
        fifo_evt    = rx_valid && rx_sof && hdr_pend;
        cnt_in      = rx_sof ? '0 : cnt_q;
        cnt_new     = cnt_in + LW'(1);
        drop_in     = rx_sof ? 1'b0 : drop_q;
        sym_in      = rx_sof ? rx_err : (sym_q || rx_err);
        fits        = ((LW+1)'(cnt_new) + (LW+1)'(SPACE_MARGIN)) <= (LW+1)'(free);
        drop_new    = drop_in || !fits;
        wr_byte     = live && !drop_new;
        commit_next = live && rx_eof && !drop_new;
        drop_evt    = live && rx_eof && drop_new;
    end

    // Payload address behind the header slot, folded unless linear mode is on.
    always_comb begin
        lin_addr  = wr_ptr + AW'(HDR_BYTES) + AW'(cnt_in);
        byte_addr = cfg_nowrap ? lin_addr : (lin_addr & mask);
    end

    // Drive the memory port: the header in its cycle, otherwise the payload byte.
    always_comb begin
        if (hdr_pend) begin
            mem_we    = 1'b1;
            mem_be    = 4'hF;
            mem_addr  = wr_ptr;
            mem_wdata = {16'(commit_len), hdr_stat};
        end else begin
            mem_we    = wr_byte;
            mem_be    = 4'b0001 << byte_addr[1:0];
            mem_addr  = byte_addr;
            mem_wdata = {4{rx_data}};
        end
    end

    // Track the frame in progress: byte count, sticky drop and symbol error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            drop_q   <= 1'b0;
            sym_q    <= 1'b0;
            cnt_q    <= '0;
        end else if (live) begin
            in_frame <= !rx_eof;
            drop_q   <= drop_new;
            sym_q    <= sym_in;
            cnt_q    <= cnt_new;
        end
    end

    // Latch the header contents at the end beat for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_pend   <= 1'b0;
            commit_len <= '0;
            hdr_stat   <= '0;
        end else begin
            hdr_pend <= commit_next;
            if (commit_next) begin
                commit_len <= cnt_new;
                hdr_stat   <= build_status(rx_class_t'(rx_class), sym_in);
            end
        end
    end

    assign commit      = hdr_pend;
    assign commit_good = hdr_stat[0];

    assert_hdr_after_eof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_next |=> (mem_we && mem_be == 4'hF && commit));
    assert_no_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && drop_q && rx_valid && !rx_sof) |-> !mem_we);
    assert_single_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !commit) |-> $onehot0(mem_be));
endmodule

// File: rtl/rxr_stat.sv
// Event unit: write-1-to-clear event bits and the missed-frame counter.
// Assumes at most one missed frame per cycle; a set beats a same-cycle clear.
module rxr_stat
    import rxr_pkg::*;
#(
    parameter int MISS_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_ok,
    input  logic              set_err,
    input  logic              set_ovf,
    input  logic              set_fifo,
    input  logic              ack_we,
    input  logic [15:0]       ack,
    input  logic              miss_clr,
    input  logic              miss_inc,
    output logic [15:0]       int_stat,
    output logic [MISS_W-1:0] miss_cnt
);
    localparam logic [15:0] IMPL = (16'(1) << INT_OK) | (16'(1) << INT_ERR)
                                 | (16'(1) << INT_OVF) | (16'(1) << INT_FIFO);

    logic [15:0] set_vec;
    logic [15:0] clr_vec;

    // Gather this cycle's set and clear requests.
    always_comb begin
        set_vec           = '0;
        set_vec[INT_OK]   = set_ok;
        set_vec[INT_ERR]  = set_err;
        set_vec[INT_OVF]  = set_ovf;
        set_vec[INT_FIFO] = set_fifo;
        clr_vec           = ack_we ? ack : '0;
    end

    // Update the event bits, set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) int_stat <= '0;
        else        int_stat <= ((int_stat & ~clr_vec) | set_vec) & IMPL;
    end

    // Count missed frames; a clear restarts the count, keeping a same-cycle miss.
    always_ff @(posedge clk) begin
        if (!rst_n)        miss_cnt <= '0;
        else if (miss_clr) miss_cnt <= miss_inc ? MISS_W'(1) : '0;
        else if (miss_inc) miss_cnt <= miss_cnt + MISS_W'(1);
    end

    assert_ok_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_ok |=> int_stat[INT_OK]);
    assert_ok_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && ack[INT_OK] && !set_ok) |=> !int_stat[INT_OK]);
    assert_miss_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_clr && !miss_inc) |=> miss_cnt == '0);
    assert_miss_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_clr && miss_inc) |=> miss_cnt == $past(miss_cnt) + MISS_W'(1));
endmodule

// File: rtl/rxr_ring_writer.sv
// Top of the receive ring writer: connects the frame unit, the pointer unit and
// the event unit. Frames are stored with a 4-byte header, dword aligned.
// Assumes a power-of-two BASE_LEN and a largest buffer of at most 32 KiB.
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int BASE_LEN     = 8192,
    parameter int MAX_SIZE_IDX = 2,
    parameter int MISS_W       = 24
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [1:0]                                  cfg_size,
    input  logic                                        cfg_nowrap,
    input  logic                                        rx_valid,
    input  logic [7:0]                                  rx_data,
    input  logic                                        rx_sof,
    input  logic                                        rx_eof,
    input  logic                                        rx_err,
    input  logic [6:0]                                  rx_class,
    input  logic                                        rdptr_we,
    input  logic [15:0]                                 rdptr_wdata,
    input  logic                                        int_ack_we,
    input  logic [15:0]                                 int_ack,
    input  logic                                        miss_clr,
    output logic                                        mem_we,
    output logic [3:0]                                  mem_be,
    output logic [$clog2(BASE_LEN<<MAX_SIZE_IDX):0]     mem_addr,
    output logic [31:0]                                 mem_wdata,
    output logic                                        buf_empty,
    output logic [15:0]                                 int_stat,
    output logic [MISS_W-1:0]                           miss_cnt
);
    localparam int AW = $clog2(BASE_LEN << MAX_SIZE_IDX) + 1;
    localparam int LW = 16;

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] mask;
    logic [AW-1:0] free;
    logic          commit;
    logic [LW-1:0] commit_len;
    logic          commit_good;
    logic          drop_evt;
    logic          fifo_evt;

    rxr_space #(.BASE_LEN(BASE_LEN), .MAX_IDX(MAX_SIZE_IDX), .AW(AW), .LW(LW)) u_space (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_size   (cfg_size),
        .rdptr_we   (rdptr_we),
        .rdptr_wdata(rdptr_wdata),
        .commit     (commit),
        .commit_len (commit_len),
        .wr_ptr     (wr_ptr),
        .mask       (mask),
        .free       (free),
        .buf_empty  (buf_empty)
    );

    rxr_frame #(.AW(AW), .LW(LW)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_nowrap (cfg_nowrap),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_err     (rx_err),
        .rx_class   (rx_class),
        .wr_ptr     (wr_ptr),
        .mask       (mask),
        .free       (free),
        .mem_we     (mem_we),
        .mem_be     (mem_be),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .commit     (commit),
        .commit_len (commit_len),
        .commit_good(commit_good),
        .drop_evt   (drop_evt),
        .fifo_evt   (fifo_evt)
    );

    rxr_stat #(.MISS_W(MISS_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ok   (commit && commit_good),
        .set_err  (commit && !commit_good),
        .set_ovf  (drop_evt),
        .set_fifo (fifo_evt),
        .ack_we   (int_ack_we),
        .ack      (int_ack),
        .miss_clr (miss_clr),
        .miss_inc (drop_evt || fifo_evt),
        .int_stat (int_stat),
        .miss_cnt (miss_cnt)
    );

    assert_empty_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rdptr_we) |=> !buf_empty);
    assert_drop_no_header_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> !commit);
endmodule

// File: tb/tb_rxr_ring_writer.sv
// Self-checking bench: a vector table of frames, then directed tests.
module tb_rxr_ring_writer;
    localparam int BASE = 64;
    localparam int MAXI = 2;
    localparam int AW   = $clog2(BASE << MAXI) + 1;
    localparam int MEMB = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_size = 2'd0;
    logic        cfg_nowrap = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic [7:0]  rx_data = 8'd0;
    logic [6:0]  rx_class = 7'd0;
    logic        rdptr_we = 1'b0, int_ack_we = 1'b0, miss_clr = 1'b0;
    logic [15:0] rdptr_wdata = 16'd0, int_ack = 16'd0;
    logic        mem_we, buf_empty;
    logic [3:0]  mem_be;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [15:0] int_stat;
    logic [23:0] miss_cnt;

    int nchk = 0, nfail = 0, hw_cnt = 0, wr_cnt = 0;
    bit done = 0;
    logic [7:0] bm [0:MEMB-1];

    always #2 clk = ~clk;

    rxr_ring_writer #(.BASE_LEN(BASE), .MAX_SIZE_IDX(MAXI)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_nowrap(cfg_nowrap),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_err(rx_err), .rx_class(rx_class), .rdptr_we(rdptr_we),
        .rdptr_wdata(rdptr_wdata), .int_ack_we(int_ack_we), .int_ack(int_ack),
        .miss_clr(miss_clr), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .buf_empty(buf_empty), .int_stat(int_stat),
        .miss_cnt(miss_cnt));

    // Bench memory model with byte enables; counts header and total writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMB; i++) bm[i] <= 8'h00;
            hw_cnt <= 0;
            wr_cnt <= 0;
        end else if (mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) bm[(int'(mem_addr) & ~3) + b] <= mem_wdata[8*b +: 8];
            if (mem_be == 4'hF) hw_cnt <= hw_cnt + 1;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // Frame vectors: [31] consume first, [30] symbol error, [22:16] class, [15:0] length.
    localparam logic [31:0] VEC [8] = '{
        32'h0010_0014, 32'h0002_000D, 32'h0020_001E, 32'h8040_001E,
        32'hC000_0038, 32'h0000_0001, 32'h8000_0039, 32'h8008_0028 };

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 7 + i);
    endfunction

    function automatic logic [31:0] word_at(input int a);
        return {bm[a+3], bm[a+2], bm[a+1], bm[a]};
    endfunction

    function automatic logic [15:0] exp_status(input logic [6:0] c, input logic sym);
        logic [15:0] s;
        s = '0;
        s[4:1] = c[3:0];
        s[5] = sym;
        s[0] = (c[3:0] == 4'd0) && !sym;
        s[15:13] = c[6:4];
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input int seed, input int len, input logic [6:0] cls, input logic sym);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data = pat(seed, i); rx_err = sym && (i == 0); rx_class = cls;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_rd(input int off);
        @(negedge clk); rdptr_we = 1'b1; rdptr_wdata = 16'(off - 16);
        @(negedge clk); rdptr_we = 1'b0;
    endtask

    task automatic ack_ints(input logic [15:0] v);
        @(negedge clk); int_ack_we = 1'b1; int_ack = v;
        @(negedge clk); int_ack_we = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] sz, input logic nw);
        @(negedge clk); rst_n = 1'b0; cfg_size = sz; cfg_nowrap = nw;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        int ew, er, L, freeb, h0, miss_exp;
        logic [31:0] e;
        int len;
        logic [6:0] cls;
        logic sym;

        do_reset(2'd0, 1'b0);
        // R12 reset state
        chk("R12 empty after reset", 32'(buf_empty), 32'd1);
        chk("R12 int_stat after reset", 32'(int_stat), 32'd0);
        chk("R12 miss_cnt after reset", 32'(miss_cnt), 32'd0);
        chk("R12 no writes after reset", 32'(wr_cnt), 32'd0);

        ew = 0; er = 0; L = 64; miss_exp = 0;
        for (int v = 0; v < 8; v++) begin
            e = VEC[v]; len = int'(e[15:0]); cls = e[22:16]; sym = e[30];
            if (e[31]) begin
                host_rd(ew); er = ew;
                chk("R5 consumed pointer empties buffer", 32'(buf_empty), 32'd1);
            end
            freeb = (er == ew) ? L : ((er - ew) & (L - 1));
            h0 = hw_cnt;
            send_frame(v + 1, len, cls, sym);
            if (len + 8 <= freeb) begin
                chk("R2 R4 header at predicted start", word_at(ew),
                    {16'(len), exp_status(cls, sym)});
                chk("R3 first payload byte", 32'(bm[(ew + 4) & (L - 1)]), 32'(pat(v + 1, 0)));
                chk("R1 last payload byte folded", 32'(bm[(ew + 4 + len - 1) & (L - 1)]),
                    32'(pat(v + 1, len - 1)));
                chk("R8 event bit for stored frame", 32'(int_stat),
                    exp_status(cls, sym)[0] ? 32'h1 : 32'h2);
                ew = (ew + len + 7) & ~3 & (L - 1);
                chk("R6 not empty after store", 32'(buf_empty), 32'(er == ew));
            end else begin
                miss_exp++;
                chk("R7 no header for dropped frame", 32'(hw_cnt), 32'(h0));
                chk("R7 overflow bit", 32'(int_stat), 32'h10);
                chk("R7 missed count", 32'(miss_cnt), 32'(miss_exp));
            end
            ack_ints(16'hFFFF);
        end

        // R8 write-1-to-clear affects only acknowledged bits
        host_rd(ew); er = ew;
        send_frame(9, 12, 7'd0, 1'b0);
        ew = (ew + 12 + 7) & ~3 & (L - 1);
        ack_ints(16'h0002);
        chk("R8 unacked bit kept", 32'(int_stat), 32'h1);
        ack_ints(16'h0001);
        chk("R8 acked bit cleared", 32'(int_stat), 32'h0);

        // R10 missed counter cleared by a write
        @(negedge clk); miss_clr = 1'b1; @(negedge clk); miss_clr = 1'b0;
        chk("R10 missed cleared", 32'(miss_cnt), 32'd0);

        // R9 start beat in the header cycle discards the new frame
        host_rd(ew); er = ew;
        h0 = hw_cnt;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == 9);
            rx_data = pat(10, i); rx_class = 7'd0;
        end
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == 4);
            rx_data = pat(11, i);
        end
        @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
        chk("R9 one header only", 32'(hw_cnt), 32'(h0 + 1));
        chk("R9 fifo and ok bits", 32'(int_stat), 32'h41);
        chk("R9 missed count", 32'(miss_cnt), 32'd1);
        ew = (ew + 10 + 7) & ~3 & (L - 1);
        ack_ints(16'hFFFF);
        host_rd(ew); er = ew;
        send_frame(12, 8, 7'd0, 1'b0);
        chk("R9 pointer unmoved by discard", word_at(ew), {16'd8, 16'h0001});

        // R1 size index 1 wraps at 128
        do_reset(2'd1, 1'b0);
        send_frame(19, 100, 7'd0, 1'b0);
        host_rd(104);
        send_frame(20, 40, 7'd0, 1'b0);
        chk("R1 size 1 header", word_at(104), {16'd40, 16'h0001});
        chk("R1 size 1 wraps to offset 0", 32'(bm[0]), 32'(pat(20, 20)));
        chk("R1 size 1 nothing past end", 32'(bm[128]), 32'd0);

        // R1 size index above maximum acts as the maximum (256)
        do_reset(2'd3, 1'b0);
        send_frame(30, 200, 7'd0, 1'b0);
        chk("R1 clamped size stores long frame", word_at(0), {16'd200, 16'h0001});
        host_rd(204);
        send_frame(31, 60, 7'd0, 1'b0);
        chk("R1 clamped size wraps at 256", 32'(bm[0]), 32'(pat(31, 48)));

        // R11 linear mode runs past the end, pointer still folds
        do_reset(2'd0, 1'b1);
        send_frame(40, 40, 7'd0, 1'b0);
        host_rd(44);
        send_frame(41, 40, 7'd0, 1'b0);
        chk("R11 header of crossing frame", word_at(44), {16'd40, 16'h0001});
        chk("R11 byte beyond nominal end", 32'(bm[80]), 32'(pat(41, 32)));
        host_rd(24);
        send_frame(42, 8, 7'd0, 1'b0);
        chk("R11 R4 next start folded", word_at(24), {16'd8, 16'h0001});

        done = 1;
        report();
        $finish;
    end
endmodule